// File: doc/BRIEF.md
# Serial Line Transmitter with Line-Driver Enable

This block turns bytes into asynchronous serial frames on a single output line and drives an enable for a half-duplex differential line driver. A byte enters over a valid/ready handshake. The byte and the line settings present in that handshake cycle are captured. The frame then goes out one bit per pulse of `bit_tick`, a one-cycle strobe that an outside rate divider supplies. Each frame holds a low start bit, the data bits with the least significant bit first, an optional parity bit and one or two high stop bits.

Back-pressure works as follows. `in_ready` is high only when the line is idle, and in the single cycle where the tick that ends the final stop bit arrives. A source that holds `in_valid` high during a frame therefore has its next byte taken at that tick. The new frame starts without a gap, and the driver enable stays high. Data may wait on the input for any length of time. A byte is taken only in a cycle where both signals are high. A break request drops `in_ready` at once. At the next tick it forces the line low with the driver enabled, and it holds the line there until the request is withdrawn.

Top module: `sertx_line`

## Requirements
- R1: After reset, `txd` is 1, `tx_en` is 0 and `in_ready` is 1.
- R2: The start bit (0) begins at the first `bit_tick` after the handshake. Each bit lasts from one tick to the next. The order is start, data least significant bit first, parity if enabled, then stop bits (1).
- R3: With `cfg_long_word`=1, the frame carries `in_data[7:0]`. With 0, it carries `in_data[6:0]`, and `in_data[7]` is neither sent nor counted in the parity.
- R4: With `cfg_two_stop`=1, the frame ends with two stop bits. With 0, it ends with one.
- R5: `cfg_parity` selects the parity bit. 0 means no parity bit. 1 means odd: the data plus parity hold an odd number of ones. 2 means even. 3 means a constant 1. 4 means a constant 0. Codes 5 to 7 behave as 0.
- R6: `tx_en` rises in the cycle the start bit appears. It falls, together with `txd` returning to 1, at the tick that ends the last stop bit. `tx_en` is never 0 while `txd` is 0.
- R7: When `in_valid` is high at the tick that ends the last stop bit, `in_ready` is high in that cycle. The new start bit begins at that same tick, and `tx_en` stays high.
- R8: `in_ready` is low from the handshake until the final tick of the frame. A change to `in_data` or the settings after the handshake does not alter the frame.
- R9: While `brk_req` is 1, `in_ready` is 0. From the next tick on, `txd` is 0 and `tx_en` is 1 for as long as the request stays. A frame that is pending or under way is abandoned and is not resumed.
- R10: At the first tick with `brk_req` at 0 during a break, `txd` returns to 1, `tx_en` to 0 and `in_ready` to 1.
- R11: `txd` and `tx_en` change only in the cycle after a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe that marks each bit boundary |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte in this cycle |
| in_data | input | DATA_W | Byte to send |
| cfg_long_word | input | 1 | 1: eight data bits, 0: seven data bits |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_parity | input | 3 | Parity code: 0 none, 1 odd, 2 even, 3 one, 4 zero |
| brk_req | input | 1 | Hold the line low (break) while high |
| txd | output | 1 | Serial line, idles high |
| tx_en | output | 1 | Line-driver enable |

## Verification
Two events can fall on one tick: the end of a frame's last stop bit and the handshake of the next byte. The bench creates this overlap by raising `in_valid` during the final stop bit of four frames, each with different settings. It then requires a low `txd` and a high `tx_en` on the sample after that tick, so the enable shows no gap, and the following frame must match its own settings bit for bit. A break request that arrives partway through a frame is a second overlap, between the break and the serializer. The bench judges it by a low line at the next tick and by a quiet, idle line long after the release.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_SEND,
    ST_BRK
  } tx_state_e;

  typedef struct packed {
    logic       long_word;
    logic       two_stop;
    logic [2:0] par;
  } line_cfg_t;

endpackage

// File: rtl/sertx_parity.sv
module sertx_parity
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              long_word,
  input  logic [2:0]        mode,
  output logic              par_en,
  output logic              par_bit
);

  logic [DATA_W-1:0] masked;
  logic              xsum;

  always_comb begin
    masked = data;
    if (!long_word) masked[DATA_W-1] = 1'b0;
    xsum    = ^masked;
    par_en  = 1'b1;
    par_bit = 1'b1;
    case (mode)
      PAR_ODD:   par_bit = ~xsum;
      PAR_EVEN:  par_bit = xsum;
      PAR_MARK:  par_bit = 1'b1;
      PAR_SPACE: par_bit = 1'b0;
      default: begin
        par_en  = 1'b0;
        par_bit = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer #(
  parameter int DATA_W = 8,
  parameter int FW     = DATA_W + 4,
  parameter int CW     = $clog2(FW + 1)
) (
  input  logic [DATA_W-1:0] data,
  input  logic              long_word,
  input  logic              two_stop,
  input  logic              par_en,
  input  logic              par_bit,
  output logic [FW-1:0]     word,
  output logic [CW-1:0]     nbits
);

  // word[0] leaves the line first; unused upper positions stay 1 (stop level)
  always_comb begin
    int len;
    int total;
    len  = long_word ? DATA_W : DATA_W - 1;
    word = '1;
    word[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < len) word[1+i] = data[i];
    end
    for (int j = 1; j < FW; j++) begin
      if (par_en && (j == 1 + len)) word[j] = par_bit;
    end
    total = 1 + len + (par_en ? 1 : 0) + (two_stop ? 2 : 1);
    nbits = CW'(total);
  end

endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int FW = 12,
  parameter int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          brk_req,
  input  logic          in_valid,
  input  logic [FW-1:0] word,
  input  logic [CW-1:0] nbits,
  output logic          in_ready,
  output logic          txd,
  output logic          tx_en
);

  tx_state_e     state;
  logic [FW-1:0] shreg;
  logic [CW-1:0] left;
  logic          last_bit;
  logic          take;

  // left counts bits still to send after the one on the line
  assign last_bit = (left == '0);
  assign in_ready = !brk_req &&
                    ((state == ST_IDLE) ||
                     ((state == ST_SEND) && last_bit && bit_tick));
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      shreg <= '1;
      left  <= '0;
      txd   <= 1'b1;
      tx_en <= 1'b0;
    end else if (bit_tick && brk_req) begin
      state <= ST_BRK;
      left  <= '0;
      txd   <= 1'b0;
      tx_en <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take) begin
            shreg <= word;
            left  <= nbits;
            state <= ST_PEND;
          end
        end
        ST_PEND: begin
          if (bit_tick) begin
            txd   <= shreg[0];
            shreg <= {1'b1, shreg[FW-1:1]};
            left  <= left - 1'b1;
            tx_en <= 1'b1;
            state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (bit_tick) begin
            if (last_bit) begin
              if (take) begin
                txd   <= word[0];
                shreg <= {1'b1, word[FW-1:1]};
                left  <= nbits - 1'b1;
              end else begin
                txd   <= 1'b1;
                tx_en <= 1'b0;
                state <= ST_IDLE;
              end
            end else begin
              txd   <= shreg[0];
              shreg <= {1'b1, shreg[FW-1:1]};
              left  <= left - 1'b1;
            end
          end
        end
        ST_BRK: begin
          if (bit_tick) begin
            txd   <= 1'b1;
            tx_en <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_low_has_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> tx_en);

  p_txd_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(txd));

  p_en_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(tx_en));

  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_tick) && $past(brk_req)) |-> (!txd && tx_en));

  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == ST_PEND && bit_tick && !brk_req) |-> (!txd && tx_en));

  p_release_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state == ST_BRK && bit_tick && !brk_req) |-> (txd && !tx_en));

  p_left_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND) |-> (left < CW'(FW)));

endmodule

// File: rtl/sertx_line.sv
module sertx_line
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cfg_long_word,
  input  logic              cfg_two_stop,
  input  logic [2:0]        cfg_parity,
  input  logic              brk_req,
  output logic              txd,
  output logic              tx_en
);

  localparam int FW = DATA_W + 4;
  localparam int CW = $clog2(FW + 1);

  line_cfg_t     cfg;
  logic          par_en;
  logic          par_bit;
  logic [FW-1:0] word;
  logic [CW-1:0] nbits;

  assign cfg = '{long_word: cfg_long_word, two_stop: cfg_two_stop, par: cfg_parity};

  sertx_parity #(.DATA_W(DATA_W)) u_parity (
    .data      (in_data),
    .long_word (cfg.long_word),
    .mode      (cfg.par),
    .par_en    (par_en),
    .par_bit   (par_bit)
  );

  sertx_framer #(.DATA_W(DATA_W), .FW(FW), .CW(CW)) u_framer (
    .data      (in_data),
    .long_word (cfg.long_word),
    .two_stop  (cfg.two_stop),
    .par_en    (par_en),
    .par_bit   (par_bit),
    .word      (word),
    .nbits     (nbits)
  );

  sertx_engine #(.FW(FW), .CW(CW)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .brk_req  (brk_req),
    .in_valid (in_valid),
    .word     (word),
    .nbits    (nbits),
    .in_ready (in_ready),
    .txd      (txd),
    .tx_en    (tx_en)
  );

endmodule

// File: tb/sertx_line_test.sv
module sertx_line_test;

  localparam int DIV = 5;
  localparam int NV  = 8;
  // {data, long_word, two_stop, parity code, expected bit count}
  localparam logic [16:0] VEC [NV] = '{
    {8'h55, 1'b1, 1'b0, 3'd0, 4'd10},
    {8'hA3, 1'b1, 1'b1, 3'd1, 4'd12},
    {8'h0F, 1'b1, 1'b0, 3'd2, 4'd11},
    {8'hFF, 1'b0, 1'b0, 3'd3, 4'd10},
    {8'h80, 1'b0, 1'b1, 3'd4, 4'd11},
    {8'h00, 1'b1, 1'b0, 3'd1, 4'd11},
    {8'h7E, 1'b0, 1'b0, 3'd2, 4'd10},
    {8'h96, 1'b1, 1'b1, 3'd7, 4'd11}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       cfg_long_word = 1'b1;
  logic       cfg_two_stop = 1'b0;
  logic [2:0] cfg_parity = 3'd0;
  logic       brk_req = 1'b0;
  logic       txd;
  logic       tx_en;
  int         tcnt = 0;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      tcnt     <= 0;
      bit_tick <= 1'b0;
    end else begin
      tcnt     <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
      bit_tick <= (tcnt == DIV - 1);
    end
  end

  sertx_line #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_long_word(cfg_long_word), .cfg_two_stop(cfg_two_stop),
    .cfg_parity(cfg_parity), .brk_req(brk_req),
    .txd(txd), .tx_en(tx_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!bit_tick);
    @(negedge clk);
    #1;
  endtask

  task automatic apply(input logic [16:0] v);
    in_data       = v[16:9];
    cfg_long_word = v[8];
    cfg_two_stop  = v[7];
    cfg_parity    = v[6:4];
    in_valid      = 1'b1;
  endtask

  task automatic scramble();
    in_valid      = 1'b0;
    in_data       = ~in_data;
    cfg_long_word = ~cfg_long_word;
    cfg_two_stop  = ~cfg_two_stop;
    cfg_parity    = 3'd3;
  endtask

  function automatic logic [15:0] expect_bits(input logic [16:0] v);
    logic [15:0] b;
    logic [7:0]  d;
    int          len;
    logic        ones;
    b   = '1;
    d   = v[16:9];
    len = v[8] ? 8 : 7;
    if (len == 7) d[7] = 1'b0;
    ones = ^d;
    b[0] = 1'b0;
    for (int i = 0; i < 8; i++) if (i < len) b[1+i] = d[i];
    case (v[6:4])
      3'd1: b[1+len] = ~ones;
      3'd2: b[1+len] = ones;
      3'd3: b[1+len] = 1'b1;
      3'd4: b[1+len] = 1'b0;
      default: ;
    endcase
    return b;
  endfunction

  function automatic string bit_req(input logic [16:0] v, input int k);
    int len;
    len = v[8] ? 8 : 7;
    if (k == 0) return "R2 start bit";
    if (k <= len) return "R3 data bit";
    if ((v[6:4] >= 3'd1) && (v[6:4] <= 3'd4) && (k == len + 1)) return "R5 parity bit";
    return "R4 stop bit";
  endfunction

  task automatic send(input logic [16:0] v, input bit chained,
                      input bit chain_next, input logic [16:0] nxt);
    logic [15:0] eb;
    int n;
    eb = expect_bits(v);
    n  = int'(v[3:0]);
    if (!chained) begin
      while (!in_ready) settle();
      apply(v);
      settle();
      scramble();
    end
    for (int k = 0; k < n; k++) begin
      wait_tick();
      if (chained && k == 0) begin
        chk("R7 start right after previous stop", {31'd0, txd}, 32'd0);
        scramble();
      end
      chk(bit_req(v, k), {31'd0, txd}, {31'd0, eb[k]});
      chk("R6 enable during frame", {31'd0, tx_en}, 32'd1);
      chk("R8 ready low in frame", {31'd0, in_ready}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      #1;
      chk("R11 line steady between ticks", {31'd0, txd}, {31'd0, eb[k]});
    end
    if (chain_next) begin
      apply(nxt);
    end else begin
      wait_tick();
      chk("R6 line idle after frame", {31'd0, txd}, 32'd1);
      chk("R6 enable off after frame", {31'd0, tx_en}, 32'd0);
      chk("R8 ready after frame", {31'd0, in_ready}, 32'd1);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R1-all: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 txd in reset", {31'd0, txd}, 32'd1);
    chk("R1 tx_en in reset", {31'd0, tx_en}, 32'd0);
    rst_n = 1'b1;
    settle();
    chk("R1 txd after reset", {31'd0, txd}, 32'd1);
    chk("R1 tx_en after reset", {31'd0, tx_en}, 32'd0);
    chk("R1 ready after reset", {31'd0, in_ready}, 32'd1);

    // table walk: odd entries follow their predecessor back to back
    for (int i = 0; i < NV; i++) begin
      send(VEC[i], (i % 2) == 1, (i % 2) == 0, VEC[(i + 1) % NV]);
    end

    // break from idle
    settle();
    brk_req = 1'b1;
    #1;
    chk("R9 ready drops with break", {31'd0, in_ready}, 32'd0);
    wait_tick();
    chk("R9 break line low", {31'd0, txd}, 32'd0);
    chk("R9 break enable high", {31'd0, tx_en}, 32'd1);
    for (int j = 0; j < 3; j++) begin
      wait_tick();
      chk("R9 break held low", {31'd0, txd}, 32'd0);
      chk("R9 break enable held", {31'd0, tx_en}, 32'd1);
    end
    brk_req = 1'b0;
    #1;
    chk("R10 line low until tick", {31'd0, txd}, 32'd0);
    chk("R10 ready low until tick", {31'd0, in_ready}, 32'd0);
    wait_tick();
    chk("R10 line high after release", {31'd0, txd}, 32'd1);
    chk("R10 enable off after release", {31'd0, tx_en}, 32'd0);
    chk("R10 ready after release", {31'd0, in_ready}, 32'd1);

    // break in the middle of a frame
    while (!in_ready) settle();
    apply(VEC[0]);
    settle();
    scramble();
    wait_tick();
    chk("R2 start before break", {31'd0, txd}, 32'd0);
    wait_tick();
    wait_tick();
    brk_req = 1'b1;
    wait_tick();
    chk("R9 mid-frame break low", {31'd0, txd}, 32'd0);
    chk("R9 mid-frame break enable", {31'd0, tx_en}, 32'd1);
    brk_req = 1'b0;
    wait_tick();
    chk("R10 mid-frame release high", {31'd0, txd}, 32'd1);
    chk("R10 mid-frame release enable", {31'd0, tx_en}, 32'd0);
    for (int j = 0; j < 14; j++) begin
      wait_tick();
      chk("R9 abandoned frame stays silent", {30'd0, txd, tx_en}, 32'd2);
    end

    // recovery frame
    send(VEC[1], 1'b0, 1'b0, VEC[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule